// File: doc/BRIEF.md
# Execution Control Command Port

This block is the host-facing control slave of a small processing engine. The host sees five word registers: a data register, an address register, a combined command/status register, a completion counter and a run-time profile counter. The engine's instruction memory, its data memory and its execution context stack (ECS) registers are not mapped directly. Each access goes through an indirect sequence of three writes. The host places a value in the data register and a location in the address register, then writes a command code. A read command returns its result into the data register a fixed number of cycles later.

The same command register carries the run-control actions: start, stop, clear pipeline, clear profile counter and single step. A single step hands the word currently held in the ECS instruction slot to the engine as a one-shot request. The engine answers with a completion pulse, and each completion advances the completion counter by one. The host polls that counter to find out that the injected instruction has retired.

Top module: `exec_cmd_port`

## Requirements
- R1: After reset the status word reads 0x40800000 (bit 30 stopped, bit 23 pipeline clean), the completion counter reads 0, and the ECS registers hold their initial values: 0xA0000000, 0x01000000, 0x00008000 at indices 0..2; 0x20000080, 0x01000000, 0x00008000 at indices 4..6 and 8..10; 0x20000000, 0, 0x001E0000 at indices 12..14; 0x1003C00F at index 0x11.
- R2: A command write of code 0x11, 0x13 or 0x15 stores the data register into the instruction memory, the data memory or the ECS register selected by the address register, respectively.
- R3: A command write of code 0x10, 0x12 or 0x14 loads the addressed instruction memory word, data memory word or ECS register into the data register RD_LAT cycles (default 2) after the command edge. Status bit 0 (busy) reads 1 while the read is pending.
- R4: Code 0x02 sets status bit 31 (running) and clears bit 30 (stopped). Code 0x03 does the reverse. The two bits are never 1 together.
- R5: A command write while busy is ignored. A write command issued then leaves memory unchanged.
- R6: Code 0x01 is accepted only when the engine is not running and no step is outstanding. It raises a one-cycle step request that carries the ECS instruction slot (index 0x11) and sets status bit 1 (step pending). Each completion pulse clears bit 1 and increments the completion counter (bus register 3), which the host may also overwrite.
- R7: Code 0x04 sets status bit 29 (cleared), and a start or an accepted step clears it again. Bit 23 reads 1 exactly when the engine is neither running nor stepping.
- R8: The profile counter (bus register 4) counts the clock edges at which the engine is running. Code 0x0C zeroes it.
- R9: ECS indices that hold no register read as 0 and ignore writes.
- R10: An undefined command code changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register select: 0 data, 1 address, 2 command/status, 3 completion counter, 4 profile counter |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Write data; command code in bits 7:0 |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| eng_step_req | output | 1 | One-cycle request to execute the injected instruction |
| eng_instr | output | 32 | Instruction word sent with the step request |
| eng_step_done | input | 1 | Engine pulse: the stepped instruction has completed |

## Verification
The checker assumes three things about its inputs. The engine pulses completion only while a step is outstanding. The host never overwrites the completion counter in the same cycle as a completion. It also issues at most one bus access per cycle. The bench models the engine with a fixed delay from request to a single completion pulse. It keeps its own counter writes away from step windows and drives every access through a task that holds the strobe for exactly one cycle.

// File: rtl/ecp_pkg.sv
`timescale 1ns/1ps
package ecp_pkg;
  typedef enum logic [7:0] {
    OP_STEP     = 8'h01,
    OP_START    = 8'h02,
    OP_HALT     = 8'h03,
    OP_FLUSH    = 8'h04,
    OP_PROF_CLR = 8'h0C,
    OP_IRD      = 8'h10,
    OP_IWR      = 8'h11,
    OP_DRD      = 8'h12,
    OP_DWR      = 8'h13,
    OP_CRD      = 8'h14,
    OP_CWR      = 8'h15
  } op_e;

  typedef enum logic [1:0] {SRC_IMEM, SRC_DMEM, SRC_CTX} src_e;

  localparam logic [2:0] BA_DATA  = 3'd0;
  localparam logic [2:0] BA_ADDR  = 3'd1;
  localparam logic [2:0] BA_CMD   = 3'd2;
  localparam logic [2:0] BA_WATCH = 3'd3;
  localparam logic [2:0] BA_PROF  = 3'd4;

  localparam int CTX_INSTR_IDX = 17;

  // Which ECS indices hold a register: four levels of three, plus the instruction slot.
  function automatic logic ctx_present(input int idx);
    return ((idx < 15) && ((idx % 4) != 3)) || (idx == CTX_INSTR_IDX);
  endfunction

  function automatic logic [31:0] ctx_reset(input int idx);
    logic [31:0] v;
    if (idx == CTX_INSTR_IDX) v = 32'h1003C00F;
    else if (idx >= 15 || (idx % 4) == 3) v = 32'h0;
    else if (idx >= 12) begin
      // debug level
      case (idx % 4)
        0:       v = 32'h20000000;
        1:       v = 32'h00000000;
        default: v = 32'h001E0000;
      endcase
    end else begin
      case (idx % 4)
        0:       v = (idx == 0) ? 32'hA0000000 : 32'h20000080;
        1:       v = 32'h01000000;
        default: v = 32'h00008000;
      endcase
    end
    return v;
  endfunction
endpackage

// File: rtl/ecp_ram.sv
`timescale 1ns/1ps
module ecp_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ecp_ctx_file.sv
`timescale 1ns/1ps
module ecp_ctx_file
  import ecp_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] instr
);
  localparam int NREG = 1 << AW;
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (ctx_present(i)) begin : g_live
      always_ff @(posedge clk) begin
        if (rst) regs[i] <= DW'(ctx_reset(i));
        else if (we && waddr == AW'(i)) regs[i] <= wdata;
      end
    end else begin : g_hole
      assign regs[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) rdata <= regs[raddr];
  end

  assign instr = regs[CTX_INSTR_IDX];
endmodule

// File: rtl/exec_cmd_port.sv
`timescale 1ns/1ps
module exec_cmd_port
  import ecp_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int CTX_AW  = 5,
  parameter int RD_LAT  = 2,
  parameter int CNT_W   = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  bus_addr,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        eng_step_req,
  output logic [31:0] eng_instr,
  input  logic        eng_step_done
);
  localparam int LW = $clog2(RD_LAT + 1);

  logic [31:0]    data_reg, addr_reg;
  logic           running, stopped, cleared, step_pend;
  logic [CNT_W-1:0] watch, prof;
  logic [LW-1:0]  rd_cnt;
  src_e           rd_src;
  logic           busy, cmd_wr, step_ok;
  logic [7:0]     code;
  logic [31:0]    imem_q, dmem_q, ctx_q, ctx_instr, rd_mux, status;

  assign busy   = (rd_cnt != '0);
  assign code   = bus_wdata[7:0];
  assign cmd_wr = bus_we && (bus_addr == BA_CMD) && !busy;
  assign step_ok = cmd_wr && (code == OP_STEP) && !running && !step_pend;

  ecp_ram #(.AW(IMEM_AW), .DW(32)) u_imem (
    .clk(clk),
    .we(cmd_wr && code == OP_IWR), .waddr(addr_reg[IMEM_AW-1:0]), .wdata(data_reg),
    .re(cmd_wr && code == OP_IRD), .raddr(addr_reg[IMEM_AW-1:0]), .rdata(imem_q));

  ecp_ram #(.AW(DMEM_AW), .DW(32)) u_dmem (
    .clk(clk),
    .we(cmd_wr && code == OP_DWR), .waddr(addr_reg[DMEM_AW-1:0]), .wdata(data_reg),
    .re(cmd_wr && code == OP_DRD), .raddr(addr_reg[DMEM_AW-1:0]), .rdata(dmem_q));

  ecp_ctx_file #(.AW(CTX_AW), .DW(32)) u_ctx (
    .clk(clk), .rst(rst),
    .we(cmd_wr && code == OP_CWR), .waddr(addr_reg[CTX_AW-1:0]), .wdata(data_reg),
    .re(cmd_wr && code == OP_CRD), .raddr(addr_reg[CTX_AW-1:0]), .rdata(ctx_q),
    .instr(ctx_instr));

  always_comb begin
    case (rd_src)
      SRC_IMEM: rd_mux = imem_q;
      SRC_DMEM: rd_mux = dmem_q;
      default:  rd_mux = ctx_q;
    endcase
  end

  assign status = {running, stopped, cleared, 5'b0, (!running && !step_pend),
                   21'b0, step_pend, busy};

  // Indirect read sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt <= '0;
      rd_src <= SRC_IMEM;
    end else if (cmd_wr && (code == OP_IRD || code == OP_DRD || code == OP_CRD)) begin
      rd_cnt <= LW'(RD_LAT);
      rd_src <= (code == OP_IRD) ? SRC_IMEM : (code == OP_DRD) ? SRC_DMEM : SRC_CTX;
    end else if (busy) begin
      rd_cnt <= rd_cnt - 1'b1;
    end
  end

  // Host registers
  always_ff @(posedge clk) begin
    if (rst) begin
      data_reg <= '0;
      addr_reg <= '0;
    end else begin
      if (bus_we && bus_addr == BA_DATA) data_reg <= bus_wdata;
      if (bus_we && bus_addr == BA_ADDR) addr_reg <= bus_wdata;
      if (rd_cnt == LW'(1)) data_reg <= rd_mux;
    end
  end

  // Run control, step and counters
  always_ff @(posedge clk) begin
    if (rst) begin
      running      <= 1'b0;
      stopped      <= 1'b1;
      cleared      <= 1'b0;
      step_pend    <= 1'b0;
      eng_step_req <= 1'b0;
      eng_instr    <= '0;
      watch        <= '0;
      prof         <= '0;
    end else begin
      eng_step_req <= 1'b0;
      if (running) prof <= prof + 1'b1;
      if (cmd_wr) begin
        case (code)
          OP_START:    begin running <= 1'b1; stopped <= 1'b0; cleared <= 1'b0; end
          OP_HALT:     begin running <= 1'b0; stopped <= 1'b1; end
          OP_FLUSH:    cleared <= 1'b1;
          OP_PROF_CLR: prof <= '0;
          default: ;
        endcase
      end
      if (step_ok) begin
        step_pend    <= 1'b1;
        eng_step_req <= 1'b1;
        eng_instr    <= ctx_instr;
        cleared      <= 1'b0;
      end
      if (eng_step_done && step_pend) begin
        step_pend <= 1'b0;
        watch     <= watch + 1'b1;
      end
      if (bus_we && bus_addr == BA_WATCH) watch <= CNT_W'(bus_wdata);
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_re;
      if (bus_re) begin
        case (bus_addr)
          BA_DATA:  bus_rdata <= data_reg;
          BA_ADDR:  bus_rdata <= addr_reg;
          BA_CMD:   bus_rdata <= status;
          BA_WATCH: bus_rdata <= 32'(watch);
          BA_PROF:  bus_rdata <= 32'(prof);
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ecp_checker.sv
`timescale 1ns/1ps
module ecp_checker #(
  parameter int RD_LAT = 2,
  parameter int CNT_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             running,
  input logic             stopped,
  input logic             step_req,
  input logic             step_pend,
  input logic             step_done,
  input logic [CNT_W-1:0] watch,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic             busy
);
  logic [7:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;
  end

  a_r4_run_stop_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(running && stopped));

  a_r6_step_req_pulse: assert property (@(posedge clk) disable iff (rst)
    step_req |=> !step_req);

  a_r6_step_only_halted: assert property (@(posedge clk) disable iff (rst)
    step_req |-> (!running && step_pend));

  a_r6_watch_advance: assert property (@(posedge clk) disable iff (rst)
    (step_done && step_pend && !(bus_we && bus_addr == 3'd3)) |=> (watch == $past(watch) + 1'b1));

  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    32'(busy_run) <= RD_LAT);
endmodule

bind exec_cmd_port ecp_checker #(.RD_LAT(RD_LAT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .running(running), .stopped(stopped),
  .step_req(eng_step_req), .step_pend(step_pend), .step_done(eng_step_done),
  .watch(watch), .bus_we(bus_we), .bus_addr(bus_addr), .busy(busy));

// File: tb/exec_cmd_port_tb.sv
`timescale 1ns/1ps
module exec_cmd_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        eng_step_req;
  logic [31:0] eng_instr;
  logic        eng_step_done = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] seen_instr = '0;
  int          seen_reqs = 0;
  int          eng_cnt = 0;

  always #10 clk = ~clk;

  exec_cmd_port u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .eng_step_req(eng_step_req), .eng_instr(eng_instr), .eng_step_done(eng_step_done));

  // Engine model: one completion pulse four edges after a request
  always @(posedge clk) begin
    eng_step_done <= 1'b0;
    if (eng_step_req) begin
      eng_cnt    <= 3;
      seen_instr <= eng_instr;
      seen_reqs  <= seen_reqs + 1;
    end else if (eng_cnt != 0) begin
      eng_cnt <= eng_cnt - 1;
      if (eng_cnt == 1) eng_step_done <= 1'b1;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per returned read
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) check(bus_rdata, 32'hDEAD_DEAD, "unexpected read");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic bw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic br(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic ind_wr(input logic [7:0] op, input logic [31:0] a, input logic [31:0] d);
    bw(3'd0, d); bw(3'd1, a); bw(3'd2, {24'h0, op});
  endtask

  task automatic ind_rd(input logic [7:0] op, input logic [31:0] a, input logic [31:0] exp,
                        input string tag);
    bw(3'd1, a); bw(3'd2, {24'h0, op});
    repeat (3) @(negedge clk);
    br(3'd0, exp, tag);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    br(3'd2, 32'h4080_0000, "R1 status after reset");
    br(3'd3, 32'h0, "R1 counter after reset");
    ind_rd(8'h14, 32'd0,  32'hA000_0000, "R1 ECS bg reg0");
    ind_rd(8'h14, 32'd9,  32'h0100_0000, "R1 ECS pri2 reg1");
    ind_rd(8'h14, 32'd14, 32'h001E_0000, "R1 ECS dbg reg2");
    ind_rd(8'h14, 32'd17, 32'h1003_C00F, "R1 ECS instr slot");

    // R2 indirect writes, read back
    ind_wr(8'h13, 32'd7, 32'h1234_0007);
    ind_rd(8'h12, 32'd7, 32'h1234_0007, "R2 data memory");
    ind_wr(8'h11, 32'd5, 32'hABCD_0005);
    ind_wr(8'h11, 32'd6, 32'hABCD_0006);
    ind_rd(8'h10, 32'd5, 32'hABCD_0005, "R2 instruction memory");
    ind_wr(8'h15, 32'd4, 32'h1234_5678);
    ind_rd(8'h14, 32'd4, 32'h1234_5678, "R2 ECS register");

    // R3 busy while a read is pending
    bw(3'd1, 32'd6); bw(3'd2, 32'h10);
    br(3'd2, 32'h4080_0001, "R3 busy bit during read");
    repeat (3) @(negedge clk);
    br(3'd0, 32'hABCD_0006, "R3 data after latency");
    br(3'd2, 32'h4080_0000, "R3 busy cleared");

    // R5 command while busy ignored
    bw(3'd0, 32'h0000_5555); bw(3'd1, 32'd7);
    bw(3'd2, 32'h12);
    bw(3'd2, 32'h13);
    repeat (3) @(negedge clk);
    ind_rd(8'h12, 32'd7, 32'h1234_0007, "R5 write during busy dropped");

    // R9 hole in ECS space
    ind_wr(8'h15, 32'd3, 32'hFFFF_FFFF);
    ind_rd(8'h14, 32'd3, 32'h0, "R9 unimplemented ECS index");

    // R10 undefined code
    bw(3'd0, 32'h0BAD_0BAD);
    bw(3'd2, 32'h07);
    br(3'd2, 32'h4080_0000, "R10 status after undefined code");
    br(3'd0, 32'h0BAD_0BAD, "R10 data after undefined code");

    // R6 single step of injected instruction
    ind_wr(8'h15, 32'd17, 32'hCAFE_0011);
    bw(3'd2, 32'h01);
    br(3'd2, 32'h4000_0002, "R6 step pending status");
    repeat (8) @(negedge clk);
    check(seen_instr, 32'hCAFE_0011, "R6 step carries instruction slot");
    br(3'd3, 32'd1, "R6 counter after step");

    // R7 clear-pipeline flag and its release by a step
    bw(3'd2, 32'h04);
    br(3'd2, 32'h6080_0000, "R7 cleared flag set");
    bw(3'd2, 32'h01);
    repeat (8) @(negedge clk);
    br(3'd2, 32'h4080_0000, "R7 cleared flag dropped by step");
    br(3'd3, 32'd2, "R6 counter after second step");

    // R4 run state; R6 step refused while running
    bw(3'd2, 32'h02);
    br(3'd2, 32'h8000_0000, "R4 running status");
    bw(3'd2, 32'h01);
    repeat (8) @(negedge clk);
    br(3'd3, 32'd2, "R6 step ignored while running");
    check(32'(seen_reqs), 32'd2, "R6 no request while running");
    bw(3'd2, 32'h03);
    br(3'd2, 32'h4080_0000, "R4 stopped status");

    // R8 profile counter
    bw(3'd2, 32'h0C);
    br(3'd4, 32'd0, "R8 profile cleared");
    bw(3'd2, 32'h02);
    repeat (5) @(posedge clk);
    bw(3'd2, 32'h03);
    br(3'd4, 32'd6, "R8 profile counts running edges");
    bw(3'd2, 32'h0C);
    br(3'd4, 32'd0, "R8 profile clear command");

    // R6 counter overwrite by host
    bw(3'd3, 32'd100);
    br(3'd3, 32'd100, "R6 counter host write");

    repeat (4) @(negedge clk);
    check(32'(exp_q.size()), 32'd0, "scoreboard drained");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule